// File: doc/BRIEF.md
# I2C Controller Interrupt Vector Unit

This unit sits beside the protocol engine of an I2C master controller. It takes that engine's one-cycle event pulses and records each one in a sticky status flag. A software-written enable mask selects which flags may raise the interrupt line. When one or more enabled flags are pending, a vector register reports the highest-priority one as a 3-bit code, so an interrupt handler can loop on that register until it reads zero.

Flags are cleared in three ways. A handler can write ones to the status register. Reading the vector clears the event it reports, except for the two data-ready events. Those clear only when the data register is accessed, which the engine signals with a read strobe on the receive side or a write strobe on the transmit side. Two live levels from the engine, receive-shift-full and bus busy, are also shown in the status register. The register bus is a simple 16-bit word interface. Reads are combinational on the address. The read strobe carries the side effects.

Top module: `i2c_irq_vec`

## Requirements
- R1: A synchronous reset clears every event flag and every mask bit, so that the interrupt line is low and the status, mask and vector registers read zero.
- R2: An event pulse sets its sticky flag from the next clock edge. The status register (address 0) shows the flags at these bits: arbitration lost 0, NACK 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 6.
- R3: The mask register (address 1) is written from write data bits 6:0 and reads back in those bits. Mask bit k enables the event at status bit k. Bits 15:7 read zero.
- R4: The interrupt line is high exactly when at least one flag is set together with its mask bit.
- R5: The vector register (address 2) reads, in bits 2:0, the code of the pending enabled event with the lowest code. The codes are: arbitration lost 1, NACK 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed as slave 7.
- R6: The vector reads 0 when no enabled flag is pending. A flag whose mask bit is clear is ignored by both the vector and the interrupt line.
- R7: A read strobe at address 2 clears the flag whose code the vector shows, for codes 1, 2, 3, 6 and 7. For codes 4 and 5 the flag is left set.
- R8: Writing the status register clears each flag in bits 6:0 whose write bit is one and leaves the others unchanged. A write of zero has no effect. Bits 11 and 12 are not writable.
- R9: The receive-data read strobe clears the receive-ready flag. The transmit-data write strobe clears the transmit-ready flag.
- R10: When an event pulse and any clear of the same flag happen in the same cycle, the flag ends set.
- R11: Status bit 11 follows the receive-shift-full input and bit 12 follows the bus-busy input, in the same cycle. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_arb_lost_i | input | 1 | Arbitration-lost event pulse |
| ev_nack_i | input | 1 | NACK event pulse |
| ev_acc_rdy_i | input | 1 | Access-ready event pulse |
| ev_rx_rdy_i | input | 1 | Receive-ready event pulse |
| ev_tx_rdy_i | input | 1 | Transmit-ready event pulse |
| ev_stop_i | input | 1 | Stop-detected event pulse |
| ev_slave_addr_i | input | 1 | Addressed-as-slave event pulse |
| rx_shift_full_i | input | 1 | Receive shift register full level |
| bus_busy_i | input | 1 | Bus busy level |
| rx_data_rd_i | input | 1 | Receive data register was read |
| tx_data_wr_i | input | 1 | Transmit data register was written |
| reg_addr_i | input | 2 | Register word address |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on address |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs: event pulses and access strobes are clean 0/1 levels sampled at the rising edge, read and write are not both issued in one cycle, and the address is steady while a strobe is high. The bench changes inputs only at the falling edge and never raises a read and a write together. Its random phase also draws events, data strobes and both live levels freely, so that set-versus-clear collisions and vector reads during new events occur often.

// File: rtl/i2c_irq_vec_pkg.sv
package i2c_irq_vec_pkg;

    localparam int NUM_EV  = 7;
    localparam int CODE_W  = 3;
    localparam int RADDR_W = 2;

    // event index = status bit = mask bit; code = index + 1
    localparam int EV_ARB   = 0;
    localparam int EV_NACK  = 1;
    localparam int EV_ACC   = 2;
    localparam int EV_RXR   = 3;
    localparam int EV_TXR   = 4;
    localparam int EV_STOP  = 5;
    localparam int EV_SLAVE = 6;

    localparam int ST_RSFULL_BIT = 11;
    localparam int ST_BUSY_BIT   = 12;

    typedef enum logic [RADDR_W-1:0] {
        RA_STATUS = 2'd0,
        RA_MASK   = 2'd1,
        RA_VECTOR = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    typedef struct packed {
        logic      rd;
        logic      wr;
        reg_addr_e addr;
    } bus_req_t;

    // ready events are consumed by data access, not by the vector read
    function automatic logic vec_read_clears(input logic [CODE_W-1:0] code);
        return (code != '0) &&
               (code != CODE_W'(EV_RXR + 1)) &&
               (code != CODE_W'(EV_TXR + 1));
    endfunction

endpackage

// File: rtl/i2c_irq_vec_flag_bank.sv
module i2c_irq_vec_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flag_q;

    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[k] <= 1'b0;
            else if (set_i[k])
                flag_q[k] <= 1'b1;
            else if (clr_i[k])
                flag_q[k] <= 1'b0;
        end

        // R2 R10
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> flags_o[k]);

        // R8
        flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !flags_o[k]);
    end

    assign flags_o = flag_q;

    // R1
    flag_reset_chk: assert property (@(posedge clk)
        rst |=> (flags_o == '0));

endmodule

// File: rtl/i2c_irq_vec_prio_enc.sv
module i2c_irq_vec_prio_enc
    import i2c_irq_vec_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic [N-1:0]      pend_i,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        code_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend_i[k])
                code_o = CODE_W'(k + 1);
        end
    end

endmodule

// File: rtl/i2c_irq_vec_reg_port.sv
module i2c_irq_vec_reg_port
    import i2c_irq_vec_pkg::*;
#(
    parameter int N      = NUM_EV,
    parameter int DATA_W = 16
) (
    input  bus_req_t          req_i,
    input  logic [N-1:0]      wbits_i,
    input  logic [N-1:0]      flags_i,
    input  logic [N-1:0]      mask_i,
    input  logic              rsfull_i,
    input  logic              busy_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N-1:0]      w1c_o,
    output logic              mask_we_o,
    output logic [N-1:0]      vec_clr_o
);

    always_comb begin
        rdata_o = '0;
        unique case (req_i.addr)
            RA_STATUS: begin
                rdata_o[N-1:0]       = flags_i;
                rdata_o[ST_RSFULL_BIT] = rsfull_i;
                rdata_o[ST_BUSY_BIT]   = busy_i;
            end
            RA_MASK:   rdata_o[N-1:0]      = mask_i;
            RA_VECTOR: rdata_o[CODE_W-1:0] = code_i;
            default:   rdata_o = '0;
        endcase
    end

    always_comb begin
        w1c_o = '0;
        if (req_i.wr && req_i.addr == RA_STATUS)
            w1c_o = wbits_i;
    end

    assign mask_we_o = req_i.wr && (req_i.addr == RA_MASK);

    always_comb begin
        vec_clr_o = '0;
        if (req_i.rd && req_i.addr == RA_VECTOR && vec_read_clears(code_i))
            vec_clr_o[int'(code_i) - 1] = 1'b1;
    end

endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec
    import i2c_irq_vec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_arb_lost_i,
    input  logic              ev_nack_i,
    input  logic              ev_acc_rdy_i,
    input  logic              ev_rx_rdy_i,
    input  logic              ev_tx_rdy_i,
    input  logic              ev_stop_i,
    input  logic              ev_slave_addr_i,
    input  logic              rx_shift_full_i,
    input  logic              bus_busy_i,
    input  logic              rx_data_rd_i,
    input  logic              tx_data_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam int N = NUM_EV;

    ev_vec_t           ev_set, data_clr, w1c, vec_clr, flags, mask_q, pend;
    logic [CODE_W-1:0] code;
    logic              mask_we;
    bus_req_t          req;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:N];

    always_comb begin
        ev_set           = '0;
        ev_set[EV_ARB]   = ev_arb_lost_i;
        ev_set[EV_NACK]  = ev_nack_i;
        ev_set[EV_ACC]   = ev_acc_rdy_i;
        ev_set[EV_RXR]   = ev_rx_rdy_i;
        ev_set[EV_TXR]   = ev_tx_rdy_i;
        ev_set[EV_STOP]  = ev_stop_i;
        ev_set[EV_SLAVE] = ev_slave_addr_i;

        data_clr         = '0;
        data_clr[EV_RXR] = rx_data_rd_i;
        data_clr[EV_TXR] = tx_data_wr_i;
    end

    assign req.rd   = reg_rd_i;
    assign req.wr   = reg_wr_i;
    assign req.addr = reg_addr_e'(reg_addr_i);

    i2c_irq_vec_flag_bank #(.N(N)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (ev_set),
        .clr_i   (w1c | vec_clr | data_clr),
        .flags_o (flags)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= reg_wdata_i[N-1:0];
    end

    assign pend  = flags & mask_q;
    assign irq_o = |pend;

    i2c_irq_vec_prio_enc #(.N(N)) u_enc (
        .pend_i (pend),
        .code_o (code)
    );

    i2c_irq_vec_reg_port #(.N(N), .DATA_W(DATA_W)) u_port (
        .req_i     (req),
        .wbits_i   (reg_wdata_i[N-1:0]),
        .flags_i   (flags),
        .mask_i    (mask_q),
        .rsfull_i  (rx_shift_full_i),
        .busy_i    (bus_busy_i),
        .code_i    (code),
        .rdata_o   (reg_rdata_o),
        .w1c_o     (w1c),
        .mask_we_o (mask_we),
        .vec_clr_o (vec_clr)
    );

    // R4 R6
    irq_vs_vec_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (code != '0));

    // R5
    vec_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (code != '0) |-> (flags[int'(code) - 1] && mask_q[int'(code) - 1]));

    // R5
    vec_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (code != '0) |-> ((pend & ((ev_vec_t'(1) << (int'(code) - 1)) - ev_vec_t'(1))) == '0));

    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_addr_i == 2'd1) |=> (mask_q == $past(reg_wdata_i[N-1:0])));

    // R7
    vec_rd_keep_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && reg_addr_i == 2'd2 && code == CODE_W'(EV_RXR + 1) && !rx_data_rd_i && !reg_wr_i)
        |=> flags[EV_RXR]);

    // R7
    vec_rd_clr_arb_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && reg_addr_i == 2'd2 && code == CODE_W'(EV_ARB + 1) && !ev_arb_lost_i)
        |=> !flags[EV_ARB]);

    // R9
    tx_data_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_data_wr_i && !ev_tx_rdy_i) |=> !flags[EV_TXR]);

endmodule

// File: tb/i2c_irq_vec_tb.sv
module i2c_irq_vec_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  ev = '0;
    logic        rsfull = 1'b0, busy = 1'b0;
    logic        rx_rd = 1'b0, tx_wr = 1'b0;
    logic [1:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    bit m_flag[7];
    bit m_mask[7];

    always #2.5 clk = ~clk;

    i2c_irq_vec u_dut (
        .clk(clk), .rst(rst),
        .ev_arb_lost_i(ev[0]), .ev_nack_i(ev[1]), .ev_acc_rdy_i(ev[2]),
        .ev_rx_rdy_i(ev[3]), .ev_tx_rdy_i(ev[4]), .ev_stop_i(ev[5]),
        .ev_slave_addr_i(ev[6]),
        .rx_shift_full_i(rsfull), .bus_busy_i(busy),
        .rx_data_rd_i(rx_rd), .tx_data_wr_i(tx_wr),
        .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic int model_code();
        for (int k = 0; k < 7; k++)
            if (m_flag[k] && m_mask[k]) return k + 1;
        return 0;
    endfunction

    function automatic logic [15:0] model_rdata();
        logic [15:0] r = '0;
        case (addr)
            2'd0: begin
                for (int k = 0; k < 7; k++) r[k] = m_flag[k];
                r[11] = rsfull;
                r[12] = busy;
            end
            2'd1: for (int k = 0; k < 7; k++) r[k] = m_mask[k];
            2'd2: r = 16'(model_code());
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_advance();
        int code = model_code();
        for (int k = 0; k < 7; k++) begin
            bit clr = 0;
            if (wr && addr == 2'd0 && wdata[k]) clr = 1;
            if (rd && addr == 2'd2 && code == k + 1 && code != 4 && code != 5) clr = 1;
            if (k == 3 && rx_rd) clr = 1;
            if (k == 4 && tx_wr) clr = 1;
            if (ev[k]) m_flag[k] = 1;
            else if (clr) m_flag[k] = 0;
        end
        if (wr && addr == 2'd1)
            for (int k = 0; k < 7; k++) m_mask[k] = wdata[k];
    endtask

    // called just after a falling edge with inputs set; compares, advances, clears strobes
    task automatic step(input string tag);
        bit exp_irq = 0;
        #1;
        for (int k = 0; k < 7; k++) if (m_flag[k] && m_mask[k]) exp_irq = 1;
        chk({tag, "/irq R4"}, {15'd0, irq}, {15'd0, exp_irq});
        chk({tag, "/rdata"}, rdata, model_rdata());
        model_advance();
        @(negedge clk);
        ev = '0; rd = 0; wr = 0; rx_rd = 0; tx_wr = 0;
    endtask

    task automatic hard(input string tag, input logic [15:0] exp);
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 7; k++) begin m_flag[k] = 0; m_mask[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        addr = 2'd0; hard("R1 status", 16'h0000); step("R1");
        addr = 2'd1; hard("R1 mask", 16'h0000); step("R1");
        addr = 2'd2; hard("R1 vector", 16'h0000); step("R1");

        // R2 flags set while masked off; R6 no irq, vector 0
        ev = 7'h7F; addr = 2'd0; step("R2");
        hard("R2 status all flags", 16'h007F); step("R2");
        addr = 2'd2; hard("R6 vector masked", 16'h0000); step("R6");

        // R3 mask write
        addr = 2'd1; wr = 1; wdata = 16'hFF7F; step("R3");
        hard("R3 mask readback", 16'h007F); step("R3");

        // R5 R7 drain by vector reads
        addr = 2'd2;
        hard("R5 code arb", 16'd1); rd = 1; step("R7");
        hard("R5 code nack", 16'd2); rd = 1; step("R7");
        hard("R5 code acc", 16'd3); rd = 1; step("R7");
        hard("R5 code rxr", 16'd4); rd = 1; step("R7");
        hard("R7 rxr kept", 16'd4); rx_rd = 1; step("R9");
        hard("R9 code txr", 16'd5); rd = 1; step("R7");
        hard("R7 txr kept", 16'd5); tx_wr = 1; step("R9");
        hard("R5 code stop", 16'd6); rd = 1; step("R7");
        hard("R5 code slave", 16'd7); rd = 1; step("R7");
        hard("R6 vector empty", 16'd0); step("R6");

        // R8 write one to clear
        ev = 7'h7F; step("R8");
        addr = 2'd0; wr = 1; wdata = 16'h0000; step("R8");
        hard("R8 zero write", 16'h007F); step("R8");
        wr = 1; wdata = 16'h1805; step("R8");
        hard("R8 partial clear", 16'h007A); step("R8");
        wr = 1; wdata = 16'hFFFF; step("R8");
        hard("R8 full clear", 16'h0000); step("R8");

        // R10 set wins over clear
        ev = 7'h19; wr = 1; wdata = 16'h0019; step("R10");
        hard("R10 w1c collision", 16'h0019); step("R10");
        ev = 7'h08; rx_rd = 1; step("R10");
        hard("R10 data collision", 16'h0019); step("R10");

        // R6 mask cleared hides pending flags
        addr = 2'd1; wr = 1; wdata = 16'h0000; step("R6");
        addr = 2'd2; hard("R6 masked vector", 16'h0000); step("R6");

        // R11 live levels and spare address
        addr = 2'd0; rsfull = 1; hard("R11 rsfull", 16'h0819); step("R11");
        busy = 1; rsfull = 0; hard("R11 busy", 16'h1019); step("R11");
        addr = 2'd3; hard("R11 spare", 16'h0000); step("R11");
        busy = 0;

        // random traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            for (int k = 0; k < 7; k++) ev[k] = ($urandom_range(0, 7) == 0);
            addr   = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 3))
                0: rd = 1;
                1: wr = 1;
                default: ;
            endcase
            wdata  = 16'($urandom);
            rx_rd  = ($urandom_range(0, 5) == 0);
            tx_wr  = ($urandom_range(0, 5) == 0);
            rsfull = 1'($urandom);
            busy   = 1'($urandom);
            step("R5 rand");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule